// File: doc/BRIEF.md
# Windowed Multiplicity Coincidence Trigger

The block watches a bank of per-board trigger lines, grouped into crates, and decides that an event has happened when enough distinct enabled lines rise together. A line contributes when its sampled level goes from low to high. The first such edge opens a coincidence window. The block decides in the cycle where the number of distinct contributing lines inside the open window reaches the required multiplicity. Physics and calibration operation each have their own window length and multiplicity, and a mode input picks between them.

All time settings use the same encoding. A setting x gives x+2 clock cycles, which is 4 ns·x + 8 ns at a 250 MHz clock. After each decision the block issues a one-cycle trigger pulse once the programmed delay has passed. It also holds off further decisions for a programmed dead time and counts every decision in a 32-bit counter. An output enable suppresses only the pulse. Run control clears the counter through a synchronous clear input.

Cycle numbering used below: an edge "occurs in cycle t" when the line is first sampled high at clock edge t. A decision made at edge d becomes visible on the registered outputs after that edge.

Top module: `mult_coinc_trigger`

## Requirements
- R1: A line counts only on a low-to-high transition. A line held high gives no further edge. A line that rises several times inside one window counts once.
- R2: With multiplicity N and window setting x, the decision is made at the edge where the count of distinct edged lines reaches N. The window covers the x+2 cycles that start with the cycle of the edge that opened it, and edges in its last cycle still count. `decision_cnt` shows the increment after that edge.
- R3: If a window ends without reaching N, its count is discarded, and the next qualifying edge opens a fresh window.
- R4: Bit 10c+k of `active_mask` enables line k of crate c (lines are numbered the same way). Edges on lines whose mask bit is 0 are ignored and do not open a window.
- R5: When `calib_mode` is 0, `phys_win`/`phys_mult` apply. When it is 1, `calib_win`/`calib_mult` apply. The window length is taken when the window opens.
- R6: A multiplicity of 0 behaves like 1: a single qualifying edge decides.
- R7: Given a decision at edge d and delay setting y, `trig_out` is high for exactly one cycle. That cycle follows clock edge d+y+1, so the pulse comes y+2 cycles after the decision.
- R8: After a decision, `busy` stays high for max(z,y)+2 cycles, where z is the dead-time setting and y the delay setting. No decision is made while `busy` is high, and edges seen during that time are discarded.
- R9: `decision_cnt` increases by exactly one for each decision, whatever the value of `out_en`.
- R10: `cnt_clr` high at a clock edge leaves `decision_cnt` at zero after that edge, even when a decision occurs at the same edge.
- R11: `trig_out` is high only when `out_en` is high during the pulse cycle. `out_en` does not change decisions, busy timing or the counter.
- R12: While reset is asserted and just after it, `trig_out` and `busy` are 0 and `decision_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_lines | input | 40 | Per-board trigger lines, line k of crate c at bit 10c+k |
| active_mask | input | 40 | Per-line enable, same bit layout |
| calib_mode | input | 1 | 0 physics settings, 1 calibration settings |
| out_en | input | 1 | Enables the trigger pulse |
| cnt_clr | input | 1 | Synchronous clear of the decision counter |
| phys_win | input | 4 | Physics window setting x (x+2 cycles) |
| calib_win | input | 4 | Calibration window setting |
| phys_mult | input | 6 | Physics multiplicity 0..40 |
| calib_mult | input | 6 | Calibration multiplicity 0..40 |
| delay_sel | input | 16 | Decision-to-pulse delay setting |
| dead_sel | input | 16 | Dead-time setting |
| trig_out | output | 1 | One-cycle delayed trigger pulse |
| busy | output | 1 | Delay or dead time running |
| decision_cnt | output | 32 | Count of decisions |

## Verification
The hardest situation to reach is a window that expires one cycle short of its multiplicity and is then followed at once by an edge that must open a fresh window. Without the reset of the count, that edge would complete the old one. The bench reaches it by placing edges on distinct lines at exact cycle offsets: two edges early in a window, none in its last cycle, a third one cycle after the window closes, and more after that. It then checks that the counter moves only when the new window fills. A similar timing pattern puts edges inside the dead time and then one edge in the first cycle after `busy` falls.

// File: rtl/mct_pkg.sv
package mct_pkg;

  typedef enum logic {
    MODE_PHYS  = 1'b0,
    MODE_CALIB = 1'b1
  } trig_mode_e;

endpackage

// File: rtl/mct_rst_sync.sv
module mct_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/mct_edge_front.sv
module mct_edge_front #(
  parameter int CRATES      = 4,
  parameter int CRATE_LINES = 10,
  localparam int NL         = CRATES * CRATE_LINES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] lines,
  input  logic [NL-1:0] mask,
  output logic [NL-1:0] edges
);

  logic [NL-1:0] prev_q;
  logic [NL-1:0] prev_d;

  always_comb prev_d = lines;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  // one slice per crate: new high level, gated by that crate's enables
  for (genvar c = 0; c < CRATES; c++) begin : g_crate
    assign edges[c*CRATE_LINES +: CRATE_LINES] =
      lines[c*CRATE_LINES +: CRATE_LINES] &
      ~prev_q[c*CRATE_LINES +: CRATE_LINES] &
      mask[c*CRATE_LINES +: CRATE_LINES];
  end

endmodule

// File: rtl/mct_window.sv
module mct_window #(
  parameter int NL    = 40,
  parameter int WIN_W = 4,
  parameter int MUL_W = 6,
  localparam int REM_W = WIN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allow,
  input  logic [NL-1:0]    edges,
  input  logic [WIN_W-1:0] win_x,
  input  logic [MUL_W-1:0] mult,
  output logic             fire
);

  logic             open_q, open_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic [NL-1:0]    seen_q, seen_d;
  logic [NL-1:0]    cand;
  logic [MUL_W-1:0] hits;
  logic [MUL_W-1:0] need;
  logic             any_edge;

  always_comb begin
    cand     = open_q ? (seen_q | edges) : edges;
    any_edge = |edges;
    hits     = '0;
    for (int i = 0; i < NL; i++) hits = hits + MUL_W'(cand[i]);
    need     = (mult == '0) ? MUL_W'(1) : mult;
    fire     = allow && (hits >= need);
  end

  always_comb begin
    open_d = open_q;
    rem_d  = rem_q;
    seen_d = seen_q;
    if (!allow || fire) begin
      open_d = 1'b0;
      rem_d  = '0;
      seen_d = '0;
    end else if (!open_q) begin
      if (any_edge) begin
        open_d = 1'b1;
        seen_d = edges;
        rem_d  = REM_W'(win_x) + REM_W'(1);
      end
    end else if (rem_q == REM_W'(1)) begin
      open_d = 1'b0;
      rem_d  = '0;
      seen_d = '0;
    end else begin
      seen_d = cand;
      rem_d  = rem_q - REM_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rem_q  <= '0;
      seen_q <= '0;
    end else begin
      open_q <= open_d;
      rem_q  <= rem_d;
      seen_q <= seen_d;
    end
  end

endmodule

// File: rtl/mct_countdown.sv
module mct_countdown #(
  parameter int W = 16,
  localparam int CW = W + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] len_x,
  output logic         active,
  output logic         last
);

  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    cnt_en = start || act_q;
    if (start) begin
      act_d = 1'b1;
      cnt_d = CW'(len_x) + CW'(1);
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign active = act_q;
  assign last   = act_q && (cnt_q == '0);

endmodule

// File: rtl/mult_coinc_trigger.sv
module mult_coinc_trigger #(
  parameter int CRATES      = 4,
  parameter int CRATE_LINES = 10,
  parameter int WIN_W       = 4,
  parameter int MUL_W       = 6,
  parameter int DLY_W       = 16,
  parameter int DEAD_W      = 16,
  parameter int CNT_W       = 32,
  localparam int NL         = CRATES * CRATE_LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NL-1:0]     trig_lines,
  input  logic [NL-1:0]     active_mask,
  input  logic              calib_mode,
  input  logic              out_en,
  input  logic              cnt_clr,
  input  logic [WIN_W-1:0]  phys_win,
  input  logic [WIN_W-1:0]  calib_win,
  input  logic [MUL_W-1:0]  phys_mult,
  input  logic [MUL_W-1:0]  calib_mult,
  input  logic [DLY_W-1:0]  delay_sel,
  input  logic [DEAD_W-1:0] dead_sel,
  output logic              trig_out,
  output logic              busy,
  output logic [CNT_W-1:0]  decision_cnt
);

  import mct_pkg::*;

  logic             rst_sn;
  logic [NL-1:0]    edges;
  trig_mode_e       mode;
  logic [WIN_W-1:0] win_sel;
  logic [MUL_W-1:0] mult_sel;
  logic             fire;
  logic             dly_act, dly_last, dead_act, dead_last;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  mct_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  mct_edge_front #(.CRATES(CRATES), .CRATE_LINES(CRATE_LINES)) u_front (
    .clk(clk), .rst_n(rst_sn), .lines(trig_lines), .mask(active_mask),
    .edges(edges)
  );

  always_comb begin
    mode     = trig_mode_e'(calib_mode);
    win_sel  = (mode == MODE_CALIB) ? calib_win  : phys_win;
    mult_sel = (mode == MODE_CALIB) ? calib_mult : phys_mult;
  end

  mct_window #(.NL(NL), .WIN_W(WIN_W), .MUL_W(MUL_W)) u_win (
    .clk(clk), .rst_n(rst_sn), .allow(!busy), .edges(edges),
    .win_x(win_sel), .mult(mult_sel), .fire(fire)
  );

  mct_countdown #(.W(DLY_W)) u_delay (
    .clk(clk), .rst_n(rst_sn), .start(fire), .len_x(delay_sel),
    .active(dly_act), .last(dly_last)
  );

  mct_countdown #(.W(DEAD_W)) u_dead (
    .clk(clk), .rst_n(rst_sn), .start(fire), .len_x(dead_sel),
    .active(dead_act), .last(dead_last)
  );

  assign busy     = dly_act | dead_act;
  assign trig_out = dly_last & out_en;

  always_comb begin
    cnt_en = cnt_clr || fire;
    cnt_d  = cnt_clr ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign decision_cnt = cnt_q;

endmodule

// File: rtl/mct_checker.sv
module mct_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_en,
  input logic             cnt_clr,
  input logic             trig_out,
  input logic             busy,
  input logic [CNT_W-1:0] decision_cnt
);

  p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !trig_out);

  p_pulse_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out);

  p_pulse_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> busy);

  p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (decision_cnt == '0));

  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_clr) |-> (decision_cnt == $past(decision_cnt) ||
                         decision_cnt == $past(decision_cnt) + CNT_W'(1)));

  p_busy_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(cnt_clr)) |-> decision_cnt == $past(decision_cnt) + CNT_W'(1));

endmodule

bind mult_coinc_trigger mct_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_en(out_en), .cnt_clr(cnt_clr),
  .trig_out(trig_out), .busy(busy), .decision_cnt(decision_cnt)
);

// File: tb/test_mult_coinc_trigger.sv
module test_mult_coinc_trigger;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [39:0] lines, mask;
  logic        calib_mode, out_en, cnt_clr;
  logic [3:0]  phys_win, calib_win;
  logic [5:0]  phys_mult, calib_mult;
  logic [15:0] delay_sel, dead_sel;
  logic        trig_out, busy;
  logic [31:0] decision_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  mult_coinc_trigger i_mult_coinc_trigger (
    .clk(clk), .rst_n(rst_n), .trig_lines(lines), .active_mask(mask),
    .calib_mode(calib_mode), .out_en(out_en), .cnt_clr(cnt_clr),
    .phys_win(phys_win), .calib_win(calib_win),
    .phys_mult(phys_mult), .calib_mult(calib_mult),
    .delay_sel(delay_sel), .dead_sel(dead_sel),
    .trig_out(trig_out), .busy(busy), .decision_cnt(decision_cnt)
  );

  task automatic nb();
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic base_cfg();
    mask = '1; calib_mode = 1'b0; out_en = 1'b1; cnt_clr = 1'b0;
    phys_win = 4'd2; calib_win = 4'd0; phys_mult = 6'd3; calib_mult = 6'd2;
    delay_sel = 16'd0; dead_sel = 16'd0;
  endtask

  task automatic quiet();
    lines = '0;
    repeat (4) nb();
    for (int i = 0; i < 200 && busy; i++) nb();
  endtask

  function automatic logic [39:0] b(int i);
    return 40'd1 << i;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; lines = '0; base_cfg();
    repeat (3) nb();
    chk("R12", "trig in reset", trig_out, 0);
    chk("R12", "busy in reset", busy, 0);
    chk("R12", "cnt in reset", decision_cnt, 0);
    rst_n = 1'b1;
    repeat (4) nb();
    chk("R12", "cnt after reset", decision_cnt, 0);
    chk("R12", "busy after reset", busy, 0);
  endtask

  task automatic t_coinc_r2();
    logic [31:0] c0;
    base_cfg(); quiet(); c0 = decision_cnt;
    lines = b(0); nb();
    lines = b(5); nb();
    nb();
    chk("R2", "no decision before Nth edge", decision_cnt, c0);
    lines = b(12); nb();
    chk("R2", "cnt after last-cycle edge", decision_cnt, c0 + 1);
    chk("R8", "busy after decision", busy, 1);
    chk("R7", "no pulse at d+1", trig_out, 0);
    nb();
    chk("R7", "pulse at d+2 for delay 0", trig_out, 1);
    nb();
    chk("R7", "pulse one cycle", trig_out, 0);
  endtask

  task automatic t_expire_r3();
    logic [31:0] c0;
    base_cfg(); quiet(); c0 = decision_cnt;
    lines = b(0); nb();
    lines = b(1); nb();
    nb(); nb();
    lines = b(2); nb();
    lines = b(3); nb();
    chk("R3", "expired count discarded", decision_cnt, c0);
    lines = b(4); nb();
    chk("R3", "fresh window decides", decision_cnt, c0 + 1);
  endtask

  task automatic t_once_r1();
    logic [31:0] c0;
    base_cfg(); phys_mult = 6'd2; phys_win = 4'd5; quiet(); c0 = decision_cnt;
    lines = b(3); nb();
    lines = '0;   nb();
    lines = b(3); nb();
    lines = '0;   nb();
    lines = b(3); repeat (4) nb();
    chk("R1", "repeated line counts once", decision_cnt, c0);
  endtask

  task automatic t_mask_r4();
    logic [31:0] c0;
    base_cfg(); phys_mult = 6'd2; phys_win = 4'd3;
    mask = ~(40'h3ff << 10); quiet(); c0 = decision_cnt;
    lines = b(15); nb();
    lines = b(2);  nb();
    nb();
    chk("R4", "masked crate-1 line ignored", decision_cnt, c0);
    lines = b(25); nb();
    chk("R4", "crate-2 line counts", decision_cnt, c0 + 1);
  endtask

  task automatic t_mode_r5();
    logic [31:0] c0;
    base_cfg(); phys_mult = 6'd40; calib_mode = 1'b1; quiet(); c0 = decision_cnt;
    lines = b(1); nb();
    lines = b(2); nb();
    chk("R5", "calib mult 2 decides", decision_cnt, c0 + 1);
    quiet(); c0 = decision_cnt;
    lines = b(1); nb();
    lines = '0;   nb();
    lines = b(2); nb();
    chk("R5", "calib window of 2 cycles expired", decision_cnt, c0);
    calib_mode = 1'b0; quiet(); c0 = decision_cnt;
    lines = b(6) | b(7); nb();
    nb();
    chk("R5", "physics mult 40 not met", decision_cnt, c0);
  endtask

  task automatic t_zero_r6();
    logic [31:0] c0;
    base_cfg(); phys_mult = 6'd0; quiet(); c0 = decision_cnt;
    lines = b(9); nb();
    chk("R6", "mult 0 single edge", decision_cnt, c0 + 1);
  endtask

  task automatic t_delay_r7();
    int first, npulse, nbusy;
    base_cfg(); phys_mult = 6'd1; delay_sel = 16'd5; quiet();
    first = -1; npulse = 0; nbusy = 0;
    lines = b(4); nb();
    for (int k = 1; k <= 12; k++) begin
      if (trig_out) begin npulse++; if (first < 0) first = k; end
      if (busy) nbusy++;
      nb();
    end
    chk("R7", "pulse cycle for delay 5", first, 7);
    chk("R7", "pulse count", npulse, 1);
    chk("R8", "busy length covers delay", nbusy, 7);
  endtask

  task automatic t_dead_r8();
    logic [31:0] c0;
    base_cfg(); phys_mult = 6'd1; dead_sel = 16'd10; quiet(); c0 = decision_cnt;
    lines = b(0); nb();
    lines = '0; nb(); nb();
    lines = b(1); repeat (9) nb();
    chk("R8", "busy in last dead cycle", busy, 1);
    nb();
    chk("R8", "busy ends after 12 cycles", busy, 0);
    chk("R8", "edge during dead time ignored", decision_cnt, c0 + 1);
    lines = b(1) | b(2); nb();
    chk("R8", "first edge after dead time", decision_cnt, c0 + 2);
  endtask

  task automatic t_outen_r11();
    logic [31:0] c0;
    int npulse;
    base_cfg(); phys_mult = 6'd1; out_en = 1'b0; quiet(); c0 = decision_cnt;
    npulse = 0;
    lines = b(8); nb();
    for (int k = 1; k <= 6; k++) begin
      if (trig_out) npulse++;
      nb();
    end
    chk("R11", "no pulse with output disabled", npulse, 0);
    chk("R9", "counted while output disabled", decision_cnt, c0 + 1);
    out_en = 1'b1;
  endtask

  task automatic t_clear_r10();
    base_cfg(); phys_mult = 6'd1; quiet();
    lines = b(3); cnt_clr = 1'b1; nb();
    cnt_clr = 1'b0;
    chk("R10", "clear wins over decision", decision_cnt, 0);
    quiet();
    lines = b(4); nb();
    chk("R9", "counts from zero after clear", decision_cnt, 1);
  endtask

  initial begin
    t_reset();
    t_coinc_r2();
    t_expire_r3();
    t_once_r1();
    t_mask_r4();
    t_mode_r5();
    t_zero_r6();
    t_delay_r7();
    t_dead_r8();
    t_outen_r11();
    t_clear_r10();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule